// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block watches a processor core's instruction-fetch address and its data-access address, and raises a debug event when a programmed comparator matches. It has six instruction breakpoint comparators and two data watchpoint comparators. The two highest-numbered breakpoints can also require the current context identifier to equal a programmed value, which ties the breakpoint to one thread. Each comparator has an enable bit and a per-byte ignore mask. Each watchpoint can be told to match on loads, on stores, or on both.

A debug host programs the comparators and a global control word through one of two register-write streams. One stream stands for the processor-side coprocessor path and the other for an external debug-port path. Both use valid/ready. The processor-side stream is always ready. The external stream is held off (ready low) in any cycle where the processor-side stream presents a write. A stalled external write must keep valid and its payload stable until it is accepted.

A global mode bit decides what an event does. In halting mode, the block raises a halt request that stays high until the host pulses resume. In monitor mode, it raises a one-cycle debug-exception request and the core keeps running. An event-source output holds the index of the comparator behind the most recent event.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset, `halt_req`, `dbg_exc`, `resume_ack` and `evt_src` are 0, every comparator and the global enable are cleared, so a fetch at address 0 raises no event, and both write streams are ready.
- R2: Register map: address 0 is global control (bit 0 enables events, bit 1 selects monitor mode). Breakpoint n has its address at 8+2n and its control word at 9+2n. Watchpoint m has its address at 24+2m and its control word at 25+2m. A control word has bit 0 = enable, bits 4:1 = ignore address byte 0..3, bit 5 = context check, bit 6 = match loads, bit 7 = match stores, bits 15:8 = context value. An enabled breakpoint matches a valid fetch whose non-ignored address bytes equal its programmed address. The event is visible on the outputs one clock after the access.
- R3: On breakpoints 4 and 5, a set context-check bit also requires `ctx_id` to equal the programmed context value. On breakpoints 0 to 3, the context-check bit has no effect.
- R4: A watchpoint matches a valid data access only if the access direction is selected in its control word (`dacc_store` 0 = load, 1 = store).
- R5: A disabled comparator never matches, and while the global enable is 0 no event is raised.
- R6: When several comparators match in one cycle, one event is reported. The lowest breakpoint index wins, and any breakpoint wins over any watchpoint. `evt_src` encodes breakpoint n as n and watchpoint m as 6+m, and it changes only on an event.
- R7: In halting mode, an event raises `halt_req`, which holds until `resume_req` is seen. The cycle after that, `halt_req` is 0 and `resume_ack` pulses for one cycle. While `halt_req` is high, no new event is taken and `evt_src` holds.
- R8: In monitor mode, an event raises `dbg_exc` for exactly one cycle and leaves `halt_req` at 0.
- R9: When both write streams present a write in the same cycle, the processor-side write is taken and `ext_wr_ready` is 0. The held external write is taken in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_valid | input | 1 | Processor-side write valid |
| cpu_wr_ready | output | 1 | Processor-side write ready (always 1) |
| cpu_wr_addr | input | 5 | Processor-side register address |
| cpu_wr_data | input | 32 | Processor-side write data |
| ext_wr_valid | input | 1 | Debug-port write valid |
| ext_wr_ready | output | 1 | Debug-port write ready |
| ext_wr_addr | input | 5 | Debug-port register address |
| ext_wr_data | input | 32 | Debug-port write data |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| ctx_id | input | 8 | Current context identifier |
| dacc_valid | input | 1 | Data access this cycle |
| dacc_addr | input | 32 | Data access address |
| dacc_store | input | 1 | 1 = store, 0 = load |
| resume_req | input | 1 | Host request to leave the halt |
| halt_req | output | 1 | Halt request to the core |
| dbg_exc | output | 1 | One-cycle debug-exception request |
| resume_ack | output | 1 | One-cycle resume acknowledge |
| evt_src | output | 3 | Comparator index of the last event |

## Verification
Directed cases cover three kinds of address pattern: exact address matches, addresses that differ only in an ignored byte lane, and addresses that differ in a compared lane. Together they show that the ignore mask is applied per byte. Context values are varied on context-capable breakpoints and on ordinary ones, which shows where the context check applies. Loads and stores are sent to watchpoints programmed for each direction. Fetches and data accesses that match at the same time, on several comparators, show the priority order. Random programming and accesses, clustered so that hits are frequent, are run in both modes. A bench model of the comparators predicts each event, and the model tells a missed event apart from a wrong source or a wrong request output.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CTX_W  = 8;
  localparam int LANES  = ADDR_W / 8;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] RA_GLOBAL  = 5'd0;
  localparam logic [REG_AW-1:0] RA_BP_BASE = 5'd8;
  localparam logic [REG_AW-1:0] RA_WP_BASE = 5'd24;

  typedef struct packed {
    logic              en;
    logic [LANES-1:0]  lane_ign;
    logic              ctx_chk;
    logic              on_load;
    logic              on_store;
    logic [CTX_W-1:0]  ctx_val;
    logic [ADDR_W-1:0] value;
  } cmp_cfg_t;
endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_wr_valid,
  output logic                          cpu_wr_ready,
  input  logic [REG_AW-1:0]             cpu_wr_addr,
  input  logic [DATA_W-1:0]             cpu_wr_data,
  input  logic                          ext_wr_valid,
  output logic                          ext_wr_ready,
  input  logic [REG_AW-1:0]             ext_wr_addr,
  input  logic [DATA_W-1:0]             ext_wr_data,
  output logic                          glob_en,
  output logic                          mon_mode,
  output cmp_cfg_t [NUM_BP-1:0]         bp_cfg,
  output cmp_cfg_t [NUM_WP-1:0]         wp_cfg
);
  // Processor-side stream wins; the debug port waits.
  assign cpu_wr_ready = 1'b1;
  assign ext_wr_ready = !cpu_wr_valid;

  logic              wr_go;
  logic [REG_AW-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_comb begin
    wr_go   = cpu_wr_valid | ext_wr_valid;
    wr_addr = cpu_wr_valid ? cpu_wr_addr : ext_wr_addr;
    wr_data = cpu_wr_valid ? cpu_wr_data : ext_wr_data;
  end

  function automatic cmp_cfg_t with_ctl(cmp_cfg_t c, logic [DATA_W-1:0] d);
    cmp_cfg_t r;
    r          = c;
    r.en       = d[0];
    r.lane_ign = d[LANES:1];
    r.ctx_chk  = d[LANES+1];
    r.on_load  = d[LANES+2];
    r.on_store = d[LANES+3];
    r.ctx_val  = d[LANES+4 +: CTX_W];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      mon_mode <= 1'b0;
    end else if (wr_go && wr_addr == RA_GLOBAL) begin
      glob_en  <= wr_data[0];
      mon_mode <= wr_data[1];
    end
  end

  cmp_cfg_t bp_q [NUM_BP];
  cmp_cfg_t wp_q [NUM_WP];

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    localparam logic [REG_AW-1:0] A_VAL = RA_BP_BASE + REG_AW'(2 * i);
    localparam logic [REG_AW-1:0] A_CTL = A_VAL + REG_AW'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bp_q[i] <= '0;
      else if (wr_go && wr_addr == A_VAL)  bp_q[i].value <= wr_data[ADDR_W-1:0];
      else if (wr_go && wr_addr == A_CTL)  bp_q[i] <= with_ctl(bp_q[i], wr_data);
    end
    assign bp_cfg[i] = bp_q[i];
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    localparam logic [REG_AW-1:0] A_VAL = RA_WP_BASE + REG_AW'(2 * j);
    localparam logic [REG_AW-1:0] A_CTL = A_VAL + REG_AW'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          wp_q[j] <= '0;
      else if (wr_go && wr_addr == A_VAL)  wp_q[j].value <= wr_data[ADDR_W-1:0];
      else if (wr_go && wr_addr == A_CTL)  wp_q[j] <= with_ctl(wp_q[j], wr_data);
    end
    assign wp_cfg[j] = wp_q[j];
  end
endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp
  import dbg_pkg::*;
#(
  parameter bit HAS_CTX  = 1'b0,
  parameter bit IS_WATCH = 1'b0
) (
  input  cmp_cfg_t          cfg,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CTX_W-1:0]  ctx_id,
  input  logic              is_store,
  output logic              hit
);
  logic [LANES-1:0] lane_ok;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_ok[k] = cfg.lane_ign[k] | (acc_addr[8*k +: 8] == cfg.value[8*k +: 8]);
  end

  logic ctx_ok, dir_ok, qual;
  assign ctx_ok = !cfg.ctx_chk || (ctx_id == cfg.ctx_val);
  assign dir_ok = is_store ? cfg.on_store : cfg.on_load;
  assign qual   = IS_WATCH ? dir_ok : (HAS_CTX ? ctx_ok : 1'b1);

  assign hit = acc_valid & cfg.en & (&lane_ok) & qual;
endmodule

// File: rtl/dbg_prio_sel.sv
module dbg_prio_sel #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  hits,
  output logic          any_hit,
  output logic [IW-1:0] idx
);
  // Lowest index wins.
  always_comb begin
    any_hit = |hits;
    idx     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dbg_event_ctl.sv
module dbg_event_ctl #(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic             mon_mode,
  input  logic             any_hit,
  input  logic [SRC_W-1:0] hit_idx,
  input  logic             resume_req,
  output logic             halt_req,
  output logic             dbg_exc,
  output logic             resume_ack,
  output logic [SRC_W-1:0] evt_src
);
  logic fire;
  assign fire = glob_en & any_hit & !halt_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req   <= 1'b0;
      dbg_exc    <= 1'b0;
      resume_ack <= 1'b0;
      evt_src    <= '0;
    end else begin
      dbg_exc    <= fire & mon_mode;
      resume_ack <= halt_req & resume_req;
      if (fire) evt_src <= hit_idx;
      if (fire && !mon_mode)         halt_req <= 1'b1;
      else if (halt_req && resume_req) halt_req <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_pkg::*;
#(
  parameter int NUM_BP     = 6,
  parameter int NUM_WP     = 2,
  parameter int NUM_CTX_BP = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_wr_valid,
  output logic                              cpu_wr_ready,
  input  logic [REG_AW-1:0]                 cpu_wr_addr,
  input  logic [DATA_W-1:0]                 cpu_wr_data,
  input  logic                              ext_wr_valid,
  output logic                              ext_wr_ready,
  input  logic [REG_AW-1:0]                 ext_wr_addr,
  input  logic [DATA_W-1:0]                 ext_wr_data,
  input  logic                              fetch_valid,
  input  logic [ADDR_W-1:0]                 fetch_addr,
  input  logic [CTX_W-1:0]                  ctx_id,
  input  logic                              dacc_valid,
  input  logic [ADDR_W-1:0]                 dacc_addr,
  input  logic                              dacc_store,
  input  logic                              resume_req,
  output logic                              halt_req,
  output logic                              dbg_exc,
  output logic                              resume_ack,
  output logic [$clog2(NUM_BP+NUM_WP)-1:0]  evt_src
);
  localparam int NUM_CMP = NUM_BP + NUM_WP;
  localparam int SRC_W   = $clog2(NUM_CMP);
  localparam int CTX_LO  = NUM_BP - NUM_CTX_BP;

  logic                  glob_en, mon_mode;
  cmp_cfg_t [NUM_BP-1:0] bp_cfg;
  cmp_cfg_t [NUM_WP-1:0] wp_cfg;
  logic [NUM_CMP-1:0]    hit_vec;
  logic                  any_hit;
  logic [SRC_W-1:0]      hit_idx;

  dbg_cfg_regs #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .ext_wr_valid(ext_wr_valid), .ext_wr_ready(ext_wr_ready),
    .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
    .glob_en(glob_en), .mon_mode(mon_mode),
    .bp_cfg(bp_cfg), .wp_cfg(wp_cfg)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp_cmp
    dbg_addr_cmp #(.HAS_CTX(i >= CTX_LO), .IS_WATCH(1'b0)) u_cmp (
      .cfg(bp_cfg[i]), .acc_valid(fetch_valid), .acc_addr(fetch_addr),
      .ctx_id(ctx_id), .is_store(1'b0), .hit(hit_vec[i])
    );
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp_cmp
    dbg_addr_cmp #(.HAS_CTX(1'b0), .IS_WATCH(1'b1)) u_cmp (
      .cfg(wp_cfg[j]), .acc_valid(dacc_valid), .acc_addr(dacc_addr),
      .ctx_id(ctx_id), .is_store(dacc_store), .hit(hit_vec[NUM_BP+j])
    );
  end

  dbg_prio_sel #(.N(NUM_CMP), .IW(SRC_W)) u_prio (
    .hits(hit_vec), .any_hit(any_hit), .idx(hit_idx)
  );

  dbg_event_ctl #(.SRC_W(SRC_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .mon_mode(mon_mode),
    .any_hit(any_hit), .hit_idx(hit_idx), .resume_req(resume_req),
    .halt_req(halt_req), .dbg_exc(dbg_exc), .resume_ack(resume_ack),
    .evt_src(evt_src)
  );
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk #(
  parameter int SRC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr_valid,
  input logic             ext_wr_ready,
  input logic             glob_en,
  input logic             halt_req,
  input logic             dbg_exc,
  input logic             resume_req,
  input logic             resume_ack,
  input logic [SRC_W-1:0] evt_src
);
  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |=> !dbg_exc); // R8
  AST_EXC_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> !halt_req); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !resume_req) |=> halt_req); // R7
  AST_RESUME_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && resume_req) |=> (resume_ack && !halt_req)); // R7
  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> $stable(evt_src)); // R7
  AST_EXT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid |-> !ext_wr_ready); // R9
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> (!dbg_exc && !$rose(halt_req))); // R5
endmodule

bind dbg_match_unit dbg_match_unit_chk #(.SRC_W($clog2(NUM_BP+NUM_WP))) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_valid(cpu_wr_valid),
  .ext_wr_ready(ext_wr_ready), .glob_en(glob_en), .halt_req(halt_req),
  .dbg_exc(dbg_exc), .resume_req(resume_req), .resume_ack(resume_ack),
  .evt_src(evt_src)
);

// File: tb/dbg_match_unit_tb.sv
module dbg_match_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBP = 6;
  localparam int NWP = 2;
  localparam int NCTX = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        cpu_wr_valid, cpu_wr_ready, ext_wr_valid, ext_wr_ready;
  logic [4:0]  cpu_wr_addr, ext_wr_addr;
  logic [31:0] cpu_wr_data, ext_wr_data;
  logic        fetch_valid, dacc_valid, dacc_store, resume_req;
  logic [31:0] fetch_addr, dacc_addr;
  logic [7:0]  ctx_id;
  logic        halt_req, dbg_exc, resume_ack;
  logic [2:0]  evt_src;

  dbg_match_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .ext_wr_valid(ext_wr_valid), .ext_wr_ready(ext_wr_ready),
    .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .ctx_id(ctx_id),
    .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_store(dacc_store),
    .resume_req(resume_req), .halt_req(halt_req), .dbg_exc(dbg_exc),
    .resume_ack(resume_ack), .evt_src(evt_src)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] sh_bp_val [NBP];
  logic [31:0] sh_bp_ctl [NBP];
  logic [31:0] sh_wp_val [NWP];
  logic [31:0] sh_wp_ctl [NWP];
  logic        sh_en, sh_mon;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void shadow_wr(logic [4:0] a, logic [31:0] d);
    if (a == 5'd0) begin
      sh_en  = d[0];
      sh_mon = d[1];
    end else if (a >= 5'd8 && a < 5'd8 + 5'(2*NBP)) begin
      if (a[0]) sh_bp_ctl[(a-8)/2] = d; else sh_bp_val[(a-8)/2] = d;
    end else if (a >= 5'd24 && a < 5'd24 + 5'(2*NWP)) begin
      if (a[0]) sh_wp_ctl[(a-24)/2] = d; else sh_wp_val[(a-24)/2] = d;
    end
  endfunction

  task automatic reg_wr(bit use_ext, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    if (use_ext) begin
      ext_wr_valid = 1'b1; ext_wr_addr = a; ext_wr_data = d;
    end else begin
      cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
    end
    @(negedge clk);
    ext_wr_valid = 1'b0;
    cpu_wr_valid = 1'b0;
    shadow_wr(a, d);
  endtask

  function automatic bit lanes_eq(logic [31:0] v, logic [31:0] a, logic [3:0] ign);
    for (int k = 0; k < 4; k++)
      if (!ign[k] && v[8*k +: 8] != a[8*k +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  // Expected comparator index, or -1 for no event.
  function automatic int exp_src(logic fv, logic [31:0] fa, logic [7:0] cx,
                                 logic dv, logic [31:0] da, logic st);
    if (!sh_en) return -1;
    if (fv)
      for (int i = 0; i < NBP; i++) begin
        logic [31:0] c = sh_bp_ctl[i];
        if (c[0] && lanes_eq(sh_bp_val[i], fa, c[4:1]) &&
            (i < NBP - NCTX || !c[5] || cx == c[15:8])) return i;
      end
    if (dv)
      for (int j = 0; j < NWP; j++) begin
        logic [31:0] c = sh_wp_ctl[j];
        if (c[0] && lanes_eq(sh_wp_val[j], da, c[4:1]) && (st ? c[7] : c[6]))
          return NBP + j;
      end
    return -1;
  endfunction

  task automatic do_resume(string req);
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
    chk(req, "resume_ack", resume_ack, 1);
    chk(req, "halt_req after resume", halt_req, 0);
    @(negedge clk);
    chk(req, "resume_ack pulse end", resume_ack, 0);
  endtask

  task automatic probe(string req, logic fv, logic [31:0] fa, logic [7:0] cx,
                       logic dv, logic [31:0] da, logic st);
    int e;
    logic [2:0] prev;
    e    = exp_src(fv, fa, cx, dv, da, st);
    prev = evt_src;
    fetch_valid = fv; fetch_addr = fa; ctx_id = cx;
    dacc_valid = dv; dacc_addr = da; dacc_store = st;
    @(negedge clk);
    fetch_valid = 1'b0; dacc_valid = 1'b0;
    if (sh_mon) begin
      chk(req, "dbg_exc (R8)", dbg_exc, (e >= 0) ? 1 : 0);
      chk(req, "halt_req in monitor (R8)", halt_req, 0);
    end else begin
      chk(req, "halt_req (R7)", halt_req, (e >= 0) ? 1 : 0);
      chk(req, "dbg_exc in halting", dbg_exc, 0);
    end
    chk(req, "evt_src (R6)", evt_src, (e >= 0) ? 32'(e) : 32'(prev));
    if (halt_req) do_resume("R7");
    else if (sh_mon && e >= 0) begin
      @(negedge clk);
      chk("R8", "dbg_exc one cycle", dbg_exc, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NBP; i++) begin sh_bp_val[i] = '0; sh_bp_ctl[i] = '0; end
    for (int j = 0; j < NWP; j++) begin sh_wp_val[j] = '0; sh_wp_ctl[j] = '0; end
    sh_en = 1'b0; sh_mon = 1'b0;
    rst_n = 1'b0;
    cpu_wr_valid = 0; ext_wr_valid = 0; cpu_wr_addr = '0; ext_wr_addr = '0;
    cpu_wr_data = '0; ext_wr_data = '0;
    fetch_valid = 0; dacc_valid = 0; fetch_addr = '0; dacc_addr = '0;
    ctx_id = '0; dacc_store = 0; resume_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "halt_req", halt_req, 0);
    chk("R1", "dbg_exc", dbg_exc, 0);
    chk("R1", "resume_ack", resume_ack, 0);
    chk("R1", "evt_src", evt_src, 0);
    chk("R1", "cpu_wr_ready", cpu_wr_ready, 1);
    chk("R1", "ext_wr_ready", ext_wr_ready, 1);
    reg_wr(0, 5'd0, 32'h1);                     // enable, halting
    probe("R1", 1, 32'h0, 8'h0, 1, 32'h0, 1);   // comparators cleared

    // R2 exact and masked lanes
    reg_wr(0, 5'd8, 32'h1000_0040);
    reg_wr(1, 5'd9, 32'h1);
    probe("R2", 1, 32'h1000_0040, 8'h0, 0, 0, 0);
    probe("R2", 1, 32'h1000_0041, 8'h0, 0, 0, 0);
    reg_wr(0, 5'd9, 32'h3);                     // ignore byte 0
    probe("R2", 1, 32'h1000_0041, 8'h0, 0, 0, 0);
    probe("R2", 1, 32'h1001_0041, 8'h0, 0, 0, 0);

    // R3 context check
    reg_wr(0, 5'd16, 32'h2000);                 // bp4 value
    reg_wr(0, 5'd17, 32'h5A21);                 // en, ctx check, ctx 5A
    probe("R3", 1, 32'h2000, 8'h5A, 0, 0, 0);
    probe("R3", 1, 32'h2000, 8'h11, 0, 0, 0);
    reg_wr(0, 5'd10, 32'h3000);                 // bp1 value
    reg_wr(1, 5'd11, 32'h3321);                 // ctx bit on plain bp
    probe("R3", 1, 32'h3000, 8'h44, 0, 0, 0);

    // R4 watchpoint direction
    reg_wr(0, 5'd24, 32'h8000);
    reg_wr(0, 5'd25, 32'h81);                   // stores only
    probe("R4", 0, 0, 0, 1, 32'h8000, 0);
    probe("R4", 0, 0, 0, 1, 32'h8000, 1);
    reg_wr(0, 5'd26, 32'h8000);
    reg_wr(0, 5'd27, 32'h41);                   // loads only
    probe("R4", 0, 0, 0, 1, 32'h8000, 0);

    // R6 priority
    reg_wr(0, 5'd12, 32'h4000);
    reg_wr(0, 5'd13, 32'h1);
    reg_wr(0, 5'd14, 32'h4000);
    reg_wr(0, 5'd15, 32'h1);
    probe("R6", 1, 32'h4000, 0, 1, 32'h8000, 1);
    probe("R6", 0, 0, 0, 1, 32'h8000, 1);

    // R7 no event while halted
    fetch_valid = 1; fetch_addr = 32'h4000;
    @(negedge clk);
    chk("R7", "halt_req", halt_req, 1);
    chk("R7", "evt_src", evt_src, 2);
    fetch_addr = 32'h1000_0040;                 // bp0 would win
    @(negedge clk);
    fetch_valid = 0;
    repeat (2) @(negedge clk);
    chk("R7", "halt held", halt_req, 1);
    chk("R7", "evt_src held", evt_src, 2);
    chk("R7", "no exc", dbg_exc, 0);
    do_resume("R7");

    // R5 disabled comparator, global disable
    reg_wr(0, 5'd13, 32'h0);
    probe("R5", 1, 32'h4000, 0, 0, 0, 0);       // bp3 now
    reg_wr(0, 5'd0, 32'h0);
    probe("R5", 1, 32'h4000, 0, 1, 32'h8000, 1);
    chk("R5", "no halt when off", halt_req, 0);

    // R8 monitor mode
    reg_wr(0, 5'd0, 32'h3);
    probe("R8", 1, 32'h4000, 0, 0, 0, 0);

    // R9 write arbitration
    @(negedge clk);
    cpu_wr_valid = 1; cpu_wr_addr = 5'd18; cpu_wr_data = 32'h5000;
    ext_wr_valid = 1; ext_wr_addr = 5'd19; ext_wr_data = 32'h1;
    #1;
    chk("R9", "ext_wr_ready held off", ext_wr_ready, 0);
    chk("R9", "cpu_wr_ready", cpu_wr_ready, 1);
    @(negedge clk);
    shadow_wr(5'd18, 32'h5000);
    cpu_wr_valid = 0;
    #1;
    chk("R9", "ext_wr_ready later", ext_wr_ready, 1);
    @(negedge clk);
    shadow_wr(5'd19, 32'h1);
    ext_wr_valid = 0;
    probe("R9", 1, 32'h5000, 0, 0, 0, 0);
    chk("R9", "bp5 source", evt_src, 5);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] v, c;
      logic [31:0] fa, da;
      logic [7:0] cx;
      string tag;
      int e;
      v = 32'h1000 + ($urandom_range(0, 7) << 4);
      c = {16'h0, ($urandom_range(0, 1) != 0) ? 8'h5A : 8'hA5,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0,
           1'($urandom_range(0, 3) != 0)};
      if (sel < 6) begin
        reg_wr(sel[0], 5'(8 + 2*sel), v);
        reg_wr(0, 5'(9 + 2*sel), c);
      end else if (sel < 8) begin
        reg_wr(1, 5'(24 + 2*(sel-6)), v);
        reg_wr(0, 5'(25 + 2*(sel-6)), c);
      end else begin
        reg_wr(0, 5'd0, {30'h0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) != 0)});
      end
      fa = 32'h1000 + ($urandom_range(0, 7) << 4) + $urandom_range(0, 1);
      da = 32'h1000 + ($urandom_range(0, 7) << 4) + $urandom_range(0, 1);
      cx = ($urandom_range(0, 1) != 0) ? 8'h5A : 8'hA5;
      begin
        logic fv = 1'($urandom_range(0, 3) != 0);
        logic dv = 1'($urandom_range(0, 1));
        logic st = 1'($urandom_range(0, 1));
        e = exp_src(fv, fa, cx, dv, da, st);
        tag = (e < 0) ? "R5" : (e < NBP) ? "R2" : "R4";
        probe(tag, fv, fa, cx, dv, da, st);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule